// File: doc/BRIEF.md
# Flash Operation Status Reporter

This block produces the polling status that a parallel NOR flash array presents while its internal program or erase algorithm runs, together with an open-drain style ready/busy indication. A host issues single-cycle write strobes (command sequence pulses) and single-cycle read strobes with an address. An internal sequencer supplies level inputs: a completion pulse, an erase-suspend request and a held-reset flag. A per-sector erase map marks the sectors that the current erase covers.

A write-pulse counter stands in for command decoding. Four accepted write strobes start a program, and six start an erase, selected by `cmd_erase`. While an algorithm runs, reads return status bits on data lines 7, 6 and 2. The other lines carry the array data presented on `arr_data`. Two independent toggle bits let the host tell an active operation from a suspended one, and let it find the sector that is being erased.

The controller is a six-state machine:
- IDLE: ready; write strobes count.
- PROG: program busy.
- ERASE: erase busy.
- SUSP_RD: erase suspended, ready; write strobes count towards a program.
- SUSP_PROG: program while an erase is suspended, busy.
- HOLD: held reset, busy.

Transitions:
- IDLE to PROG on the 4th counted strobe with `cmd_erase`=0.
- IDLE to ERASE on the 6th counted strobe with `cmd_erase`=1.
- PROG to IDLE on `seq_done`.
- ERASE to IDLE on `seq_done`.
- ERASE to SUSP_RD on `seq_susp`.
- SUSP_RD to SUSP_PROG on the 4th counted strobe.
- SUSP_RD to ERASE when `seq_susp` falls.
- SUSP_PROG to SUSP_RD on `seq_done`.
- Any state to HOLD while `hold_rst` is high.
- HOLD to IDLE when `hold_rst` is released.

Top module: `flash_status_rpt`

## Requirements
- R1: After `rst_n` the output is ready (`rb_n`=1, `rb_drive_low`=0). Each `rd_stb` gives `rd_valid` one cycle later with `rdata`. In IDLE, `rdata` equals `arr_data` sampled with the strobe.
- R2: In PROG, a read returns these bits, with all other bits taken from `arr_data`:
  - bit 7 is the complement of `wdata[7]` from the strobe that started the program;
  - bit 6 is toggle A;
  - bit 2 is 1.

  Toggle A and toggle B are both 0 after `rst_n` and are never cleared otherwise. A read returns a toggle's current value and then flips it, whenever that toggle is active for the read.
- R3: In ERASE, a read returns bit 7 = 0, bit 6 = toggle A (active) and bit 2 = toggle B. The sector number is `addr[AW-1 -: SECT_BITS]`, and toggle B is active only when the sector's `erase_map` bit is 1.
- R4: In SUSP_RD, a read from a sector whose map bit is 1 returns bit 7 = 1, bit 6 = 1 (toggle A does not flip) and bit 2 = toggle B (active).
- R5: In SUSP_RD, a read from a sector whose map bit is 0 returns `arr_data` unchanged on all bits.
- R6: In SUSP_PROG, a read returns bit 7 as the complement of the starting `wdata[7]` and bit 6 = toggle A (active). Bit 2 is 1 for a sector whose map bit is 0; for a sector whose map bit is 1 it is toggle B (active).
- R7: The busy output drives low after the clock edge that samples the 4th counted write strobe when `cmd_erase`=0, and the 6th when `cmd_erase`=1. Fewer strobes leave it released.
- R8: Write strobes that arrive while busy are not counted, so a following sequence needs its full pulse count.
- R9: Raising `seq_susp` during ERASE releases the busy output after the next edge. Dropping it in SUSP_RD drives the output low again.
- R10: While `hold_rst` is high the busy output is low. It also clears any partial pulse count.
- R11: On `seq_done` the busy output is released after that edge, and the next read returns `arr_data` on all bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_stb | input | 1 | Host write pulse (one cycle) |
| wdata | input | 8 | Host write data; bit 7 is kept for polling |
| rd_stb | input | 1 | Host read pulse (one cycle) |
| addr | input | AW | Read address; top SECT_BITS select the sector |
| arr_data | input | 8 | Array contents at `addr` |
| cmd_erase | input | 1 | Selects an erase (6 pulses) rather than a program (4) |
| seq_done | input | 1 | Sequencer: algorithm finished |
| seq_susp | input | 1 | Sequencer: erase suspended |
| hold_rst | input | 1 | Sequencer: reset held asserted |
| erase_map | input | NSECT | One bit per sector under erase or suspension |
| rdata | output | 8 | Read result |
| rd_valid | output | 1 | `rdata` valid |
| rb_drive_low | output | 1 | Open-drain pull-down enable (busy) |
| rb_n | output | 1 | Ready level: 1 released, 0 busy |

## Verification
The bench targets four kinds of fault:
- **Pulse-count boundaries.** One strobe short of four or six must keep the output ready. A counter that is off by one would go busy early, or stay ready.
- **Strobes while busy.** These are followed by a three-strobe sequence that must not start a program. A design that counted them would go busy there.
- **Held reset.** The bench repeats the same check after a held reset interrupts a partial sequence.
- **Toggle bits and erase map.** Reads alternate between sectors inside and outside the map across erase, suspend-read and suspend-program. A shared toggle bit, or toggle A flipping in suspend-read, would return wrong values on bits 6 and 2.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP_RD,
        ST_SUSP_PROG,
        ST_HOLD
    } fsr_state_e;

endpackage

// File: rtl/fsr_pulse_cnt.sv
module fsr_pulse_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_stb,
    input  logic             accept,
    input  logic [CNT_W-1:0] target,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        hit     = wr_stb && accept && (cnt_inc == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (wr_stb && accept) begin
            cnt_q <= hit ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
#(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6,
    parameter int CNT_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_rst,
    input  logic             seq_done,
    input  logic             seq_susp,
    input  logic             cmd_erase,
    input  logic             hit,
    input  logic             wr_d7,
    output fsr_state_e       st_q,
    output logic             accept,
    output logic             cnt_clr,
    output logic [CNT_W-1:0] target,
    output logic             d7_q,
    output logic             rb_low
);

    localparam logic [CNT_W-1:0] PROG_T  = CNT_W'(PROG_PULSES);
    localparam logic [CNT_W-1:0] ERASE_T = CNT_W'(ERASE_PULSES);

    fsr_state_e st_d;

    always_comb begin
        st_d = st_q;
        if (hold_rst) begin
            st_d = ST_HOLD;
        end else begin
            unique case (st_q)
                ST_IDLE:      if (hit) st_d = cmd_erase ? ST_ERASE : ST_PROG;
                ST_PROG:      if (seq_done) st_d = ST_IDLE;
                ST_ERASE:     if (seq_done) st_d = ST_IDLE;
                              else if (seq_susp) st_d = ST_SUSP_RD;
                ST_SUSP_RD:   if (hit) st_d = ST_SUSP_PROG;
                              else if (!seq_susp) st_d = ST_ERASE;
                ST_SUSP_PROG: if (seq_done) st_d = ST_SUSP_RD;
                ST_HOLD:      st_d = ST_IDLE;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            d7_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (hit) d7_q <= wr_d7;
        end
    end

    always_comb begin
        accept  = 1'b0;
        rb_low  = 1'b0;
        target  = PROG_T;
        cnt_clr = hold_rst || (st_d != st_q);
        unique case (st_q)
            ST_IDLE: begin
                accept = 1'b1;
                target = cmd_erase ? ERASE_T : PROG_T;
            end
            ST_SUSP_RD: begin
                accept = 1'b1;
                target = PROG_T;
            end
            ST_PROG, ST_ERASE, ST_SUSP_PROG, ST_HOLD: rb_low = 1'b1;
            default: rb_low = 1'b1;
        endcase
    end

endmodule

// File: rtl/fsr_read_path.sv
module fsr_read_path
    import fsr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int SECT_BITS = 2,
    parameter int NSECT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [NSECT-1:0]  erase_map,
    input  fsr_state_e        st,
    input  logic              d7,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid
);

    logic                 tog_a_q;
    logic                 tog_b_q;
    logic [SECT_BITS-1:0] sect;
    logic                 in_map;
    logic                 flip_a;
    logic                 flip_b;
    logic [DATA_W-1:0]    rd_d;

    always_comb begin
        sect   = addr[AW-1 -: SECT_BITS];
        in_map = erase_map[sect];
        rd_d   = arr_data;
        flip_a = 1'b0;
        flip_b = 1'b0;
        unique case (st)
            ST_PROG: begin
                rd_d[7] = ~d7;
                rd_d[6] = tog_a_q;
                rd_d[2] = 1'b1;
                flip_a  = 1'b1;
            end
            ST_ERASE: begin
                rd_d[7] = 1'b0;
                rd_d[6] = tog_a_q;
                rd_d[2] = tog_b_q;
                flip_a  = 1'b1;
                flip_b  = in_map;
            end
            ST_SUSP_RD: begin
                if (in_map) begin
                    rd_d[7] = 1'b1;
                    rd_d[6] = 1'b1;
                    rd_d[2] = tog_b_q;
                    flip_b  = 1'b1;
                end
            end
            ST_SUSP_PROG: begin
                rd_d[7] = ~d7;
                rd_d[6] = tog_a_q;
                rd_d[2] = in_map ? tog_b_q : 1'b1;
                flip_a  = 1'b1;
                flip_b  = in_map;
            end
            ST_IDLE, ST_HOLD: rd_d = arr_data;
            default: rd_d = arr_data;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_a_q  <= 1'b0;
            tog_b_q  <= 1'b0;
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rdata <= rd_d;
                if (flip_a) tog_a_q <= ~tog_a_q;
                if (flip_b) tog_b_q <= ~tog_b_q;
            end
        end
    end

endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
    import fsr_pkg::*;
#(
    parameter int AW           = 12,
    parameter int SECT_BITS    = 2,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 6,
    parameter int NSECT        = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [7:0]        wdata,
    input  logic              rd_stb,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        arr_data,
    input  logic              cmd_erase,
    input  logic              seq_done,
    input  logic              seq_susp,
    input  logic              hold_rst,
    input  logic [NSECT-1:0]  erase_map,
    output logic [7:0]        rdata,
    output logic              rd_valid,
    output logic              rb_drive_low,
    output logic              rb_n
);

    localparam int MAXP  = (ERASE_PULSES > PROG_PULSES) ? ERASE_PULSES : PROG_PULSES;
    localparam int CNT_W = $clog2(MAXP + 1);

    fsr_state_e       st_q;
    logic             accept;
    logic             cnt_clr;
    logic [CNT_W-1:0] target;
    logic             hit;
    logic             d7_q;
    logic             rb_low;

    fsr_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .wr_stb (wr_stb),
        .accept (accept),
        .target (target),
        .hit    (hit)
    );

    fsr_ctrl #(
        .PROG_PULSES  (PROG_PULSES),
        .ERASE_PULSES (ERASE_PULSES),
        .CNT_W        (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_rst  (hold_rst),
        .seq_done  (seq_done),
        .seq_susp  (seq_susp),
        .cmd_erase (cmd_erase),
        .hit       (hit),
        .wr_d7     (wdata[7]),
        .st_q      (st_q),
        .accept    (accept),
        .cnt_clr   (cnt_clr),
        .target    (target),
        .d7_q      (d7_q),
        .rb_low    (rb_low)
    );

    fsr_read_path #(
        .AW        (AW),
        .SECT_BITS (SECT_BITS),
        .NSECT     (NSECT)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .addr      (addr),
        .arr_data  (arr_data),
        .erase_map (erase_map),
        .st        (st_q),
        .d7        (d7_q),
        .rdata     (rdata),
        .rd_valid  (rd_valid)
    );

    assign rb_drive_low = rb_low;
    assign rb_n         = ~rb_low;

endmodule

// File: rtl/flash_status_rpt_chk.sv
module flash_status_rpt_chk
    import fsr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int SECT_BITS = 2,
    parameter int NSECT     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb,
    input logic             rd_valid,
    input logic [7:0]       rdata,
    input logic [AW-1:0]    addr,
    input logic [NSECT-1:0] erase_map,
    input logic             seq_done,
    input logic             seq_susp,
    input logic             hold_rst,
    input logic             hit,
    input logic             rb_n,
    input fsr_state_e       st_q
);

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    // R1
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    // R3
    erase_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st_q == ST_ERASE) |=> (rdata[7] == 1'b0));

    // R4
    susp_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && st_q == ST_SUSP_RD && erase_map[addr[AW-1 -: SECT_BITS]])
        |=> (rdata[7:6] == 2'b11));

    // R7
    busy_after_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !rb_n);

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> !hit);

    // R9
    susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ERASE && seq_susp && !seq_done && !hold_rst) |=> rb_n);

    // R10
    hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> !rb_n);

    // R11
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PROG && seq_done && !hold_rst) |=> rb_n);

endmodule

bind flash_status_rpt flash_status_rpt_chk #(
    .AW        (AW),
    .SECT_BITS (SECT_BITS),
    .NSECT     (NSECT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .rd_valid  (rd_valid),
    .rdata     (rdata),
    .addr      (addr),
    .erase_map (erase_map),
    .seq_done  (seq_done),
    .seq_susp  (seq_susp),
    .hold_rst  (hold_rst),
    .hit       (hit),
    .rb_n      (rb_n),
    .st_q      (st_q)
);

// File: tb/flash_status_rpt_tb.sv
module flash_status_rpt_tb;

    localparam int AW = 12;
    localparam int NS = 4;

    typedef enum int {M_IDLE, M_PROG, M_ERASE, M_SRD, M_SPROG} mode_e;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    arr_data = 8'h00;
    logic          cmd_erase = 1'b0;
    logic          seq_done = 1'b0;
    logic          seq_susp = 1'b0;
    logic          hold_rst = 1'b0;
    logic [NS-1:0] erase_map = '0;
    logic [7:0]    rdata;
    logic          rd_valid;
    logic          rb_drive_low;
    logic          rb_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    mode_e mode = M_IDLE;
    logic  t_a = 1'b0;
    logic  t_b = 1'b0;
    logic  m_d7 = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    flash_status_rpt u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wdata        (wdata),
        .rd_stb       (rd_stb),
        .addr         (addr),
        .arr_data     (arr_data),
        .cmd_erase    (cmd_erase),
        .seq_done     (seq_done),
        .seq_susp     (seq_susp),
        .hold_rst     (hold_rst),
        .erase_map    (erase_map),
        .rdata        (rdata),
        .rd_valid     (rd_valid),
        .rb_drive_low (rb_drive_low),
        .rb_n         (rb_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] expect_read(input logic [AW-1:0] a);
        logic [7:0] e;
        logic       ins;
        e   = arr_of(a);
        ins = erase_map[a[AW-1 -: 2]];
        case (mode)
            M_PROG: begin
                e[7] = ~m_d7; e[6] = t_a; e[2] = 1'b1; t_a = ~t_a;
            end
            M_ERASE: begin
                e[7] = 1'b0; e[6] = t_a; e[2] = t_b; t_a = ~t_a;
                if (ins) t_b = ~t_b;
            end
            M_SRD: begin
                if (ins) begin
                    e[7] = 1'b1; e[6] = 1'b1; e[2] = t_b; t_b = ~t_b;
                end
            end
            M_SPROG: begin
                e[7] = ~m_d7; e[6] = t_a; t_a = ~t_a;
                if (ins) begin e[2] = t_b; t_b = ~t_b; end
                else e[2] = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

    // driver: one read strobe, expectation queued for the monitor
    task automatic do_read(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        rd_stb   = 1'b1;
        addr     = a;
        arr_data = arr_of(a);
        exp_q.push_back(expect_read(a));
        tag_q.push_back(req);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wdata  = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic chk_busy(input string req, input logic exp_rb_n);
        check(req, {6'd0, rb_drive_low, rb_n}, {6'd0, ~exp_rb_n, exp_rb_n});
    endtask

    task automatic pulse_done();
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R1 unexpected read data actual=%h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_busy("R1 reset ready", 1'b1);
        do_read(12'h010, "R1 idle read");
        do_read(12'hC7F, "R1 idle read");

        // program sequence: three strobes stay ready, fourth goes busy
        cmd_erase = 1'b0;
        do_write(8'h11); do_write(8'h22); do_write(8'h33);
        chk_busy("R7 three strobes", 1'b1);
        do_write(8'h80);
        chk_busy("R7 fourth strobe busy", 1'b0);
        mode = M_PROG; m_d7 = 1'b1;
        do_read(12'h123, "R2 program read");
        do_read(12'h456, "R2 program read");
        do_read(12'h789, "R2 program read");
        do_write(8'h00); do_write(8'h00);
        pulse_done();
        chk_busy("R11 done ready", 1'b1);
        mode = M_IDLE;
        do_read(12'h3A5, "R11 array after done");
        do_write(8'h01); do_write(8'h02); do_write(8'h03);
        chk_busy("R8 busy strobes ignored", 1'b1);
        do_write(8'h00);
        chk_busy("R8 full sequence busy", 1'b0);
        mode = M_PROG; m_d7 = 1'b0;
        do_read(12'h0F0, "R2 program read d7=0");
        pulse_done();
        mode = M_IDLE;

        // erase sequence with sectors 0 and 2 in the map
        cmd_erase = 1'b1;
        erase_map = 4'b0101;
        for (int i = 0; i < 5; i++) do_write(8'h55);
        chk_busy("R7 five erase strobes", 1'b1);
        do_write(8'h30);
        chk_busy("R7 sixth strobe busy", 1'b0);
        mode = M_ERASE;
        do_read(12'h010, "R3 erase in-map");
        do_read(12'h420, "R3 erase out-of-map");
        do_read(12'h830, "R3 erase in-map");
        do_read(12'hC40, "R3 erase out-of-map");

        @(negedge clk);
        seq_susp = 1'b1;
        @(negedge clk);
        chk_busy("R9 suspend ready", 1'b1);
        mode = M_SRD;
        do_read(12'h011, "R4 suspended sector");
        do_read(12'h812, "R4 suspended sector");
        do_read(12'h413, "R5 other sector");

        cmd_erase = 1'b0;
        for (int i = 0; i < 3; i++) do_write(8'hA0);
        do_write(8'h00);
        chk_busy("R6 suspend program busy", 1'b0);
        mode = M_SPROG; m_d7 = 1'b0;
        do_read(12'h421, "R6 non-suspended sector");
        do_read(12'h022, "R6 suspended sector");
        do_read(12'hC23, "R6 non-suspended sector");
        pulse_done();
        chk_busy("R6 back to suspend read", 1'b1);
        mode = M_SRD;
        do_read(12'h024, "R4 suspended after program");

        @(negedge clk);
        seq_susp = 1'b0;
        @(negedge clk);
        chk_busy("R9 resume busy", 1'b0);
        mode = M_ERASE;
        do_read(12'h825, "R3 resumed erase");
        pulse_done();
        chk_busy("R11 erase done ready", 1'b1);
        mode = M_IDLE;
        do_read(12'h826, "R11 array after erase");

        // held reset discards a partial count
        do_write(8'h00); do_write(8'h00);
        @(negedge clk);
        hold_rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_busy("R10 hold busy", 1'b0);
        end
        hold_rst = 1'b0;
        @(negedge clk);
        chk_busy("R10 hold released", 1'b1);
        do_write(8'h00); do_write(8'h00); do_write(8'h00);
        chk_busy("R10 count cleared", 1'b1);
        do_write(8'h80);
        chk_busy("R10 fresh sequence busy", 1'b0);
        pulse_done();

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R1 missing reads actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule